// File: doc/BRIEF.md
# Video Cycle-Stealing Bus Arbiter

This block shares one memory bus between a video fetch engine and a CPU. It runs on the dot clock and divides it by eight to make the system clock. In each system cycle the low half belongs to the video side, which only reads. The high half belongs to the CPU, which may read or write. Two per-cycle strobes tell each side when its access slot starts.

Some raster lines need more video bandwidth than the low halves give. The arbiter then takes whole cycles. On character-fetch lines it takes a run of forty cycles, and each enabled sprite costs two more cycles. Three cycles before a stolen run it pulls the bus-available line low. That line feeds the CPU's ready input, and the three cycles let pending CPU writes finish. During the stolen cycles it holds the address-enable line low for both halves. A cycle counter and a line counter place these events within the line and the frame. A mode input selects a 63-cycle or a 65-cycle line.

Top module: `vid_bus_arbiter`

## Requirements
- R1: `phi0` is the dot clock divided by 8. It is low for dot positions 0..3 and high for 4..7 of every system cycle.
- R2: In a cycle that is not stolen, `aec` equals `phi0`. `vid_slot` pulses at dot 0, and `cpu_slot` pulses at dot 4 while `aec` is high.
- R3: `cycle_idx` counts 0..62 when `ntsc_mode`=0 and 0..64 when `ntsc_mode`=1, then wraps to 0. At that wrap `line_idx` increments, and it wraps from NUM_LINES-1 to 0.
- R4: A line is a character-fetch line when `line_idx` >= FIRST_VIS and (`line_idx` - FIRST_VIS) mod 8 = 0. On such a line, cycles 20..59 are stolen.
- R5: Sprite n (bit n of `sprite_en`) steals cycles 2n and 2n+1 of every line when its bit is 1. A sprite whose bit is 0 leaves those cycles to the CPU.
- R6: In a stolen cycle `aec` is low for all 8 dots, `vid_slot` pulses at dots 0 and 4, and `cpu_slot` stays low.
- R7: `ba` goes low exactly 3 cycles before the first cycle of a stolen run and stays low through the run. In those 3 lead-in cycles `aec` still follows `phi0`, and `cpu_slot` is still given so that pending writes can finish.
- R8: `ba` returns high in the first cycle after the last stolen cycle, and `aec` follows `phi0` again from that cycle.
- R9: On a character-fetch line with no sprites enabled, exactly 23 `cpu_slot` pulses occur in the 63-cycle mode and 25 in the 65-cycle mode.
- R10: While `rst` is high, `cycle_idx`, `line_idx` and the dot position are 0 and `phi0` is low. With no sprites enabled, `ba` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| ntsc_mode | input | 1 | 0: 63-cycle line, 1: 65-cycle line |
| sprite_en | input | 8 | One enable bit per sprite |
| phi0 | output | 1 | System clock, dot clock divided by 8 |
| ba | output | 1 | Bus available, to the CPU ready input |
| aec | output | 1 | Address enable, high when the CPU owns the bus |
| vid_slot | output | 1 | Strobe at the start of each video access |
| cpu_slot | output | 1 | Strobe at the start of each CPU access |
| cycle_idx | output | 7 | Cycle position within the raster line |
| line_idx | output | $clog2(NUM_LINES) | Raster line number |

## Verification
The assertions assume that `sprite_en` changes only where no stolen cycle falls within the next three cycles. They also assume that `ntsc_mode` never moves from the 65-cycle mode to the 63-cycle mode while the cycle counter is above 62. Without the first assumption, the lead-in and release checks would see a run appear or vanish mid-window. The stimulus changes these inputs only at cycle 30 of a line that is not a character-fetch line, where no stolen cycle lies within the next three cycles, and it only switches the mode from 63 to 65 cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int DOTS       = 8;
    localparam int DOT_W      = $clog2(DOTS);
    localparam int HALF_DOT   = DOTS / 2;
    localparam int CYC_W      = 7;
    localparam int LEN_SHORT  = 63;
    localparam int LEN_LONG   = 65;
    localparam int LEAD       = 3;
    localparam int FETCH_FROM = 20;
    localparam int FETCH_LEN  = 40;
    localparam int ROW_PERIOD = 8;
    localparam int SPR_N      = 8;
    localparam int SPR_CYC    = 2;

    typedef struct packed {
        logic [DOT_W-1:0] dot;
        logic             phi;
        logic             cyc_end;
    } phase_t;

    typedef enum logic [1:0] {
        OWN_VIDEO  = 2'd0,
        OWN_CPU    = 2'd1,
        OWN_STOLEN = 2'd2
    } owner_e;

    function automatic logic [CYC_W-1:0] line_len(input logic long_mode);
        return long_mode ? CYC_W'(LEN_LONG) : CYC_W'(LEN_SHORT);
    endfunction

    function automatic logic cyc_stolen(input int cyc, input logic fetch_line,
                                        input logic [SPR_N-1:0] spr);
        logic hit;
        hit = 1'b0;
        if (cyc >= 0 && cyc < SPR_N * SPR_CYC)
            hit = spr[cyc / SPR_CYC];
        if (fetch_line && cyc >= FETCH_FROM && cyc < FETCH_FROM + FETCH_LEN)
            hit = 1'b1;
        return hit;
    endfunction
endpackage

// File: rtl/arb_dot_div.sv
module arb_dot_div
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t ph
);
    logic [DOT_W-1:0] dot_q;

    always_ff @(posedge clk) begin
        if (rst) dot_q <= '0;
        else     dot_q <= dot_q + 1'b1;
    end

    assign ph.dot     = dot_q;
    assign ph.phi     = dot_q[DOT_W-1];
    assign ph.cyc_end = (dot_q == DOT_W'(DOTS - 1));
endmodule

// File: rtl/arb_raster.sv
module arb_raster
    import arb_pkg::*;
#(
    parameter int NUM_LINES = 312,
    parameter int FIRST_VIS = 48,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              long_mode,
    output logic [CYC_W-1:0]  cyc,
    output logic [LINE_W-1:0] line,
    output logic [CYC_W-1:0]  len,
    output logic              fetch_now,
    output logic              fetch_next
);
    logic [CYC_W-1:0]  cyc_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_nx;
    logic              at_last;

    function automatic logic is_fetch(input logic [LINE_W-1:0] l);
        int li;
        li = int'(l);
        return (li >= FIRST_VIS) && (((li - FIRST_VIS) % ROW_PERIOD) == 0);
    endfunction

    assign len     = line_len(long_mode);
    assign at_last = (cyc_q >= len - 1'b1);
    assign line_nx = (line_q == LINE_W'(NUM_LINES - 1)) ? '0 : line_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            line_q <= '0;
        end else if (adv) begin
            if (at_last) begin
                cyc_q  <= '0;
                line_q <= line_nx;
            end else begin
                cyc_q  <= cyc_q + 1'b1;
            end
        end
    end

    assign cyc        = cyc_q;
    assign line       = line_q;
    assign fetch_now  = is_fetch(line_q);
    assign fetch_next = is_fetch(line_nx);
endmodule

// File: rtl/arb_steal_plan.sv
module arb_steal_plan
    import arb_pkg::*;
(
    input  logic [CYC_W-1:0] cyc,
    input  logic [CYC_W-1:0] len,
    input  logic             fetch_now,
    input  logic             fetch_next,
    input  logic [SPR_N-1:0] spr,
    output logic             stolen,
    output logic             bus_free
);
    logic [LEAD:0] look;

    for (genvar k = 0; k <= LEAD; k++) begin : g_look
        logic hit;
        always_comb begin
            int   c;
            logic f;
            c = int'(cyc) + k;
            f = fetch_now;
            if (c >= int'(len)) begin
                c = c - int'(len);
                f = fetch_next;
            end
            hit = cyc_stolen(c, f, spr);
        end
        assign look[k] = hit;
    end

    assign stolen   = look[0];
    assign bus_free = ~|look;
endmodule

// File: rtl/vid_bus_arbiter.sv
module vid_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_LINES = 312,
    parameter int FIRST_VIS = 48,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ntsc_mode,
    input  logic [SPR_N-1:0]  sprite_en,
    output logic              phi0,
    output logic              ba,
    output logic              aec,
    output logic              vid_slot,
    output logic              cpu_slot,
    output logic [CYC_W-1:0]  cycle_idx,
    output logic [LINE_W-1:0] line_idx
);
    phase_t           ph;
    logic [CYC_W-1:0] len;
    logic             fetch_now;
    logic             fetch_next;
    logic             stolen;
    logic             bus_free;
    owner_e           own;

    arb_dot_div u_div (
        .clk (clk),
        .rst (rst),
        .ph  (ph)
    );

    arb_raster #(
        .NUM_LINES (NUM_LINES),
        .FIRST_VIS (FIRST_VIS),
        .LINE_W    (LINE_W)
    ) u_ras (
        .clk        (clk),
        .rst        (rst),
        .adv        (ph.cyc_end),
        .long_mode  (ntsc_mode),
        .cyc        (cycle_idx),
        .line       (line_idx),
        .len        (len),
        .fetch_now  (fetch_now),
        .fetch_next (fetch_next)
    );

    arb_steal_plan u_plan (
        .cyc        (cycle_idx),
        .len        (len),
        .fetch_now  (fetch_now),
        .fetch_next (fetch_next),
        .spr        (sprite_en),
        .stolen     (stolen),
        .bus_free   (bus_free)
    );

    always_comb begin
        if (stolen)      own = OWN_STOLEN;
        else if (ph.phi) own = OWN_CPU;
        else             own = OWN_VIDEO;
    end

    assign phi0     = ph.phi;
    assign ba       = bus_free;
    assign aec      = (own == OWN_CPU);
    assign vid_slot = (ph.dot == '0) ||
                      (own == OWN_STOLEN && ph.dot == DOT_W'(HALF_DOT));
    assign cpu_slot = (own == OWN_CPU) && (ph.dot == DOT_W'(HALF_DOT));
endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              ntsc_mode,
    input logic              phi0,
    input logic              ba,
    input logic              aec,
    input logic              vid_slot,
    input logic              cpu_slot,
    input logic [CYC_W-1:0]  cycle_idx,
    input logic [LINE_W-1:0] line_idx
);
    logic [4:0] seen;

    always_ff @(posedge clk) begin
        if (rst)               seen <= '0;
        else if (seen != 5'd31) seen <= seen + 1'b1;
    end

    assert_phi_period_R1: assert property (@(posedge clk) disable iff (rst)
        (seen >= 5'd4) |-> (phi0 != $past(phi0, 4)));

    assert_cpu_turn_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_slot |-> (aec && phi0));

    assert_cyc_range_R3: assert property (@(posedge clk) disable iff (rst)
        cycle_idx < (ntsc_mode ? CYC_W'(LEN_LONG) : CYC_W'(LEN_SHORT)));

    assert_video_owns_R6: assert property (@(posedge clk) disable iff (rst)
        vid_slot |-> !aec);

    assert_stolen_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (phi0 && !aec) |-> !ba);

    assert_lead_in_R7: assert property (@(posedge clk) disable iff (rst)
        (seen >= 5'd24 && phi0 && !aec) |-> !$past(ba, 24));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ba) |-> ($past(phi0) && !$past(aec)));

    wire unused_ok = &{1'b0, line_idx};
endmodule

bind vid_bus_arbiter arb_checker #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ntsc_mode (ntsc_mode),
    .phi0      (phi0),
    .ba        (ba),
    .aec       (aec),
    .vid_slot  (vid_slot),
    .cpu_slot  (cpu_slot),
    .cycle_idx (cycle_idx),
    .line_idx  (line_idx)
);

// File: tb/sim_vid_bus_arbiter.sv
`timescale 1ns/1ps
module sim_vid_bus_arbiter;
    localparam int NL = 20;
    localparam int FV = 3;
    localparam int LW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ntsc_mode = 1'b0;
    logic [7:0]    sprite_en = 8'h00;
    logic          phi0, ba, aec, vid_slot, cpu_slot;
    logic [6:0]    cycle_idx;
    logic [LW-1:0] line_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    int m_dot = 0, m_cyc = 0, m_line = 0;
    int ba_arr [0:64];
    int st_arr [0:64];

    always #2.5 clk = ~clk;

    vid_bus_arbiter #(.NUM_LINES(NL), .FIRST_VIS(FV)) u0 (
        .clk(clk), .rst(rst), .ntsc_mode(ntsc_mode), .sprite_en(sprite_en),
        .phi0(phi0), .ba(ba), .aec(aec), .vid_slot(vid_slot),
        .cpu_slot(cpu_slot), .cycle_idx(cycle_idx), .line_idx(line_idx)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            if (n_bad <= 40)
                $display("FAIL %s %s: actual %0d expected %0d (line %0d cycle %0d dot %0d)",
                         req, what, act, exp, m_line, m_cyc, m_dot);
        end
    endtask

    function automatic int e_len();
        return ntsc_mode ? 65 : 63;
    endfunction

    function automatic bit e_fetch(int ln);
        return ln >= FV && ((ln - FV) % 8) == 0;
    endfunction

    function automatic bit e_steal(int c, int ln);
        return (c < 16 && sprite_en[c/2]) || (e_fetch(ln) && c >= 20 && c < 60);
    endfunction

    function automatic bit e_ba();
        for (int k = 0; k <= 3; k++) begin
            int c;
            int ln;
            c = m_cyc + k;
            ln = m_line;
            if (c >= e_len()) begin
                c = c - e_len();
                ln = (ln + 1) % NL;
            end
            if (e_steal(c, ln)) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Reference position, from R1 and R3
    always @(posedge clk) begin
        if (rst) begin
            m_dot <= 0; m_cyc <= 0; m_line <= 0;
        end else if (m_dot == 7) begin
            m_dot <= 0;
            if (m_cyc >= e_len() - 1) begin
                m_cyc  <= 0;
                m_line <= (m_line + 1) % NL;
            end else begin
                m_cyc <= m_cyc + 1;
            end
        end else begin
            m_dot <= m_dot + 1;
        end
    end

    // Continuous comparison against the requirement model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit ph;
            bit st;
            ph = (m_dot >= 4);
            st = e_steal(m_cyc, m_line);
            chk("R1", "phi0", int'(phi0), int'(ph));
            chk("R6", "aec", int'(aec), int'(ph && !st));
            chk("R7", "ba", int'(ba), int'(e_ba()));
            chk("R6", "vid_slot", int'(vid_slot), int'(m_dot == 0 || (m_dot == 4 && st)));
            chk("R2", "cpu_slot", int'(cpu_slot), int'(m_dot == 4 && !st));
            chk("R3", "cycle_idx", int'(cycle_idx), m_cyc);
            chk("R3", "line_idx", int'(line_idx), m_line);
        end
    end

    task automatic wait_at(int ln, int c);
        while (!(m_line == ln && m_cyc == c && m_dot == 0)) @(negedge clk);
    endtask

    // Observe one full line from cycle 0 dot 0
    task automatic measure(int len, output int cpu_n, output int ba_low, output int st_n);
        cpu_n = 0; ba_low = 0; st_n = 0;
        for (int i = 0; i < len * 8; i++) begin
            if (cpu_slot) cpu_n++;
            if (i % 8 == 0) begin
                ba_arr[i/8] = int'(ba);
                if (!ba) ba_low++;
            end
            if (i % 8 == 4) begin
                st_arr[i/8] = int'(!aec);
                if (!aec) st_n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10", "reset phi0", int'(phi0), 0);
        chk("R10", "reset ba", int'(ba), 1);
        chk("R10", "reset aec", int'(aec), 0);
        chk("R10", "reset cycle_idx", int'(cycle_idx), 0);
        chk("R10", "reset line_idx", int'(line_idx), 0);
        chk("R10", "reset vid_slot at dot 0", int'(vid_slot), 1);
        rst = 1'b0;
        cmp_on = 1'b1;
    endtask

    task automatic t_normal();
        wait_at(1, 30);
        for (int i = 0; i < 8; i++) begin
            chk("R1", "phi0 shape", int'(phi0), int'(i >= 4));
            chk("R2", "aec follows phi0", int'(aec), int'(i >= 4));
            chk("R2", "cpu_slot position", int'(cpu_slot), int'(i == 4));
            chk("R2", "vid_slot position", int'(vid_slot), int'(i == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_fetch_short();
        int cpu_n, ba_low, st_n;
        wait_at(3, 0);
        measure(63, cpu_n, ba_low, st_n);
        chk("R9", "cpu slots on fetch line, 63", cpu_n, 23);
        chk("R4", "stolen cycles", st_n, 40);
        chk("R4", "cycle 19 not stolen", st_arr[19], 0);
        chk("R4", "cycle 20 stolen", st_arr[20], 1);
        chk("R4", "cycle 59 stolen", st_arr[59], 1);
        chk("R7", "ba low cycles", ba_low, 43);
        chk("R7", "ba high at cycle 16", ba_arr[16], 1);
        chk("R7", "ba low at cycle 17", ba_arr[17], 0);
        chk("R7", "lead-in cycle 17 keeps CPU turn", st_arr[17], 0);
        chk("R8", "ba high at cycle 60", ba_arr[60], 1);
        chk("R8", "cycle 60 back to CPU", st_arr[60], 0);
    endtask

    task automatic t_sprites();
        int cpu_n, ba_low, st_n;
        wait_at(4, 30);
        sprite_en = 8'h05;
        wait_at(5, 0);
        measure(63, cpu_n, ba_low, st_n);
        chk("R5", "sprite stolen cycles", st_n, 4);
        chk("R5", "sprite 0 cycle 0", st_arr[0], 1);
        chk("R5", "sprite 2 cycle 5", st_arr[5], 1);
        chk("R5", "disabled sprite 1 cycle 2", st_arr[2], 0);
        chk("R5", "disabled sprite 3 cycle 6", st_arr[6], 0);
        chk("R5", "cpu slots with two sprites", cpu_n, 59);
        chk("R7", "ba low cycles with sprites", ba_low, 9);
        chk("R7", "lead-in before next line at cycle 60", ba_arr[60], 0);
        chk("R8", "ba high at cycle 6", ba_arr[6], 1);
        wait_at(6, 30);
        sprite_en = 8'h00;
    endtask

    task automatic t_long_mode();
        int cpu_n, ba_low, st_n;
        wait_at(9, 30);
        ntsc_mode = 1'b1;
        wait_at(9, 64);
        chk("R3", "cycle 64 reached in 65 mode", int'(cycle_idx), 64);
        repeat (8) @(negedge clk);
        chk("R3", "wrap to line 10", int'(line_idx), 10);
        chk("R3", "wrap to cycle 0", int'(cycle_idx), 0);
        wait_at(11, 0);
        measure(65, cpu_n, ba_low, st_n);
        chk("R9", "cpu slots on fetch line, 65", cpu_n, 25);
        chk("R7", "ba low cycles, 65", ba_low, 43);
    endtask

    task automatic t_frame_wrap();
        wait_at(19, 64);
        chk("R3", "last line index", int'(line_idx), 19);
        repeat (8) @(negedge clk);
        chk("R3", "frame wrap line", int'(line_idx), 0);
        chk("R3", "frame wrap cycle", int'(cycle_idx), 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_fetch_short();
        t_sprites();
        t_long_mode();
        t_frame_wrap();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule